// File: doc/BRIEF.md
# Vectored Nesting Priority Interrupt Controller

This block gathers up to 32 interrupt sources and drives two request lines toward a processor core: a normal request and a fast request. Every source has its own mode word and vector word. The mode word sets a priority level and selects level or edge behaviour. The block keeps three bitmaps: pending, enabled and fast-forced. It also keeps a small hardware stack of the interrupts currently in service, so a handler is interrupted only by a source of strictly higher priority.

Software takes an interrupt by reading the acknowledge-vector register. That read returns the vector of the best pending source. In the same clock edge it records the source on the nesting stack and clears an edge-type pending bit. A write to the end-of-service register releases the top entry. Source 0 and any source placed in the fast-forced set feed the fast request instead of the normal one. A protect mode moves the acknowledge side effect from the read to a write, so a debugger can inspect the vector safely. A global mask bit silences both request lines.

All register traffic goes through a single-cycle strobe port. Read data is registered and appears one cycle after the read strobe. Any side effect of a read takes place on that same edge, exactly once.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, every bitmap, mode word, vector, the spurious vector and the debug-control bits are zero, the nesting stack is empty, both request outputs are low, and every register reads 0.
- R2: The mode word holds the priority in bits [2:0] and the edge select in bit 5 (1 = edge), and it reads back in that layout. A high input sets its pending bit. For a level source the pending bit follows the input. For an edge source the bit stays set until it is acknowledged or cleared by command. When a set and a clear fall on the same cycle, the set wins.
- R3: The winner is chosen among sources 1 and up that are pending, enabled and not fast-forced. The highest priority wins, and among equal priorities the lowest source number wins. When no source qualifies, the result is source 0, which means spurious.
- R4: A read of the acknowledge-vector register (0x100) returns the winner's vector, or the spurious vector when there is no winner. Outside protect mode the same edge pushes (source, priority) onto the nesting stack and clears the winner's pending bit if the winner is an edge source. Nothing is pushed or cleared for a spurious result or when the stack is full.
- R5: The normal request is high only when a winner exists and either the stack is empty or the winner's priority is strictly greater than the priority on top of the stack.
- R6: With protect mode on (debug-control bit 0), a read of 0x100 has no side effect. Any write to 0x100 performs the push-and-clear instead. Outside protect mode, writes to 0x100 do nothing.
- R7: A write to the end-of-service register (0x130) pops one stack entry if the stack is not empty. The status register (0x108) reads the source number on top of the stack, or 0 when the stack is empty.
- R8: The fast request is high when source 0, or any fast-forced source, is both pending and enabled. A read of the fast-vector register (0x104) returns vector 0 and clears pending bit 0 if source 0 is pending. Otherwise it returns vector 0 if any fast-forced source is pending, and the spurious vector if none is.
- R9: The set-pending (0x12C) and clear-pending (0x128) commands act only on edge sources and ignore bits for level sources. Enable (0x120), disable (0x124), fast-force enable (0x140) and fast-force disable (0x144) are write-one-to-set or write-one-to-clear on their bitmaps.
- R10: While the global mask (debug-control bit 1) is set, both request outputs are low and core status (0x114) reads 0. Otherwise core status shows the fast request in bit 0 and the normal request in bit 1.
- R11: Byte addresses are as follows. Mode words are at 0x000 + 4*n and vectors at 0x080 + 4*n. Pending is at 0x10C, enabled at 0x110, spurious vector at 0x134, debug control at 0x138 and the fast-forced set at 0x148. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NUM_SRC | Interrupt source levels, synchronous to clk |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 9 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid the cycle after rd_en_i |
| nirq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the controller with all 32 sources, a nesting stack only four deep and 16-bit vectors. The shallow stack means a short run of repeated acknowledges reaches the full-stack refusal. Directed sequences then cover the priority ties, the strictly-greater nesting rule, protect mode, fast forcing and the global mask. A long stretch of sparse random source activity and random register traffic follows, and a behavioural model checks both request lines and every read result on each clock.

// File: rtl/nic_pkg.sv
package nic_pkg;
   localparam int ADDR_W   = 9;
   localparam int DATA_W   = 32;
   localparam int PRI_W    = 3;
   localparam int EDGE_POS = 5;

   localparam logic [ADDR_W-1:0] RA_ACK_VEC  = 9'h100;
   localparam logic [ADDR_W-1:0] RA_FAST_VEC = 9'h104;
   localparam logic [ADDR_W-1:0] RA_TOP_SRC  = 9'h108;
   localparam logic [ADDR_W-1:0] RA_PEND     = 9'h10C;
   localparam logic [ADDR_W-1:0] RA_ENA      = 9'h110;
   localparam logic [ADDR_W-1:0] RA_CORE     = 9'h114;
   localparam logic [ADDR_W-1:0] RA_ENA_SET  = 9'h120;
   localparam logic [ADDR_W-1:0] RA_ENA_CLR  = 9'h124;
   localparam logic [ADDR_W-1:0] RA_PND_CLR  = 9'h128;
   localparam logic [ADDR_W-1:0] RA_PND_SET  = 9'h12C;
   localparam logic [ADDR_W-1:0] RA_DONE     = 9'h130;
   localparam logic [ADDR_W-1:0] RA_SPUR     = 9'h134;
   localparam logic [ADDR_W-1:0] RA_DBG      = 9'h138;
   localparam logic [ADDR_W-1:0] RA_FF_SET   = 9'h140;
   localparam logic [ADDR_W-1:0] RA_FF_CLR   = 9'h144;
   localparam logic [ADDR_W-1:0] RA_FF_STAT  = 9'h148;

   typedef logic [PRI_W-1:0] pri_t;
endpackage

// File: rtl/nic_pick.sv
module nic_pick
   import nic_pkg::*;
#(
   parameter  int NUM_SRC = 32,
   localparam int SW      = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]            qual_i,
   input  logic [NUM_SRC-1:0][PRI_W-1:0] pri_i,
   output logic                          valid_o,
   output logic [SW-1:0]                 idx_o,
   output pri_t                          pri_o
);

   // Ascending scan with a strict compare: the first source found at the
   // best level keeps the slot, so ties go to the lowest number.
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      pri_o   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (qual_i[i] && (!valid_o || pri_i[i] > pri_o)) begin
            valid_o = 1'b1;
            idx_o   = SW'(i);
            pri_o   = pri_i[i];
         end
      end
   end

endmodule

// File: rtl/nic_nest_stack.sv
module nic_nest_stack
   import nic_pkg::*;
#(
   parameter  int DEPTH = 8,
   parameter  int SW    = 5,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int IW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [SW-1:0] src_i,
   input  pri_t          pri_i,
   output logic          empty_o,
   output logic          full_o,
   output logic [SW-1:0] top_src_o,
   output pri_t          top_pri_o
);

   logic [CW-1:0] cnt_q;
   logic [SW-1:0] src_q [DEPTH];
   pri_t          pri_q [DEPTH];
   logic          push_ok, pop_ok;
   logic [IW-1:0] top_idx, wr_idx;

   assign empty_o   = (cnt_q == '0);
   assign full_o    = (cnt_q == CW'(DEPTH));
   assign push_ok   = push_i && !full_o;
   assign pop_ok    = pop_i && !empty_o;
   assign top_idx   = IW'(cnt_q - CW'(1));
   // a same-cycle pop and push replaces the top entry
   assign wr_idx    = pop_ok ? top_idx : IW'(cnt_q);
   assign top_src_o = empty_o ? '0 : src_q[top_idx];
   assign top_pri_o = empty_o ? '0 : pri_q[top_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            src_q[i] <= '0;
            pri_q[i] <= '0;
         end
      end else begin
         if (push_ok) begin
            src_q[wr_idx] <= src_i;
            pri_q[wr_idx] <= pri_i;
         end
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   assert_full_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && full_o && !pop_i |=> cnt_q == $past(cnt_q));

   assert_done_pops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i && !empty_o |=> cnt_q == $past(cnt_q) - CW'(1));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int STACK_DEPTH = 8,
   parameter int VEC_W       = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src_i,
   input  logic               rd_en_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               nirq_o,
   output logic               fiq_o
);

   localparam int SW = $clog2(NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC > 32) begin : g_bad_src
      $error("NUM_SRC must lie in 2..32");
   end
   if (STACK_DEPTH < 2) begin : g_bad_depth
      $error("STACK_DEPTH must be at least 2");
   end
   if (VEC_W < 1 || VEC_W > DATA_W) begin : g_bad_vec
      $error("VEC_W must lie in 1..32");
   end

   // ---------------- state ----------------
   logic [NUM_SRC-1:0][PRI_W-1:0] mode_pri;
   logic [NUM_SRC-1:0]            mode_edge;
   logic [VEC_W-1:0]              vec_q [NUM_SRC];
   logic [VEC_W-1:0]              spur_q;
   logic                          prot_q, gmsk_q;
   logic [NUM_SRC-1:0]            pend_q, ena_q, ff_q, pend_nxt;
   logic [DATA_W-1:0]             rdata_q, rd_mux;

   // ---------------- decode ----------------
   logic       is_rd_ack, is_wr_ack, is_rd_fast, is_done;
   logic       is_pclr, is_pset;
   logic       arr_hit, sel_mode, sel_vec;
   logic [4:0] slot;

   assign is_rd_ack  = rd_en_i && (addr_i == RA_ACK_VEC);
   assign is_wr_ack  = wr_en_i && (addr_i == RA_ACK_VEC);
   assign is_rd_fast = rd_en_i && (addr_i == RA_FAST_VEC);
   assign is_done    = wr_en_i && (addr_i == RA_DONE);
   assign is_pclr    = wr_en_i && (addr_i == RA_PND_CLR);
   assign is_pset    = wr_en_i && (addr_i == RA_PND_SET);
   assign slot       = addr_i[6:2];
   assign arr_hit    = !addr_i[8] && (addr_i[1:0] == 2'b00) &&
                       ({1'b0, slot} < 6'(NUM_SRC));
   assign sel_mode   = arr_hit && !addr_i[7];
   assign sel_vec    = arr_hit && addr_i[7];

   // ---------------- arbitration ----------------
   logic [NUM_SRC-1:0] qual;
   logic               win_valid;
   logic [SW-1:0]      win_idx;
   pri_t               win_pri;

   assign qual = pend_q & ena_q & ~ff_q & ~NUM_SRC'(1);

   nic_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .qual_i  (qual),
      .pri_i   (mode_pri),
      .valid_o (win_valid),
      .idx_o   (win_idx),
      .pri_o   (win_pri)
   );

   // ---------------- nesting stack ----------------
   logic          ack, push_ok, st_empty, st_full;
   logic [SW-1:0] st_top_src;
   pri_t          st_top_pri;

   assign ack     = win_valid && (prot_q ? is_wr_ack : is_rd_ack);
   assign push_ok = ack && !st_full;

   nic_nest_stack #(.DEPTH(STACK_DEPTH), .SW(SW)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (ack),
      .pop_i     (is_done),
      .src_i     (win_idx),
      .pri_i     (win_pri),
      .empty_o   (st_empty),
      .full_o    (st_full),
      .top_src_o (st_top_src),
      .top_pri_o (st_top_pri)
   );

   // ---------------- requests ----------------
   logic fast_req, norm_req;

   assign fast_req = |(pend_q & ena_q & (ff_q | NUM_SRC'(1)));
   assign norm_req = win_valid && (st_empty || win_pri > st_top_pri);
   assign fiq_o    = !gmsk_q && fast_req;
   assign nirq_o   = !gmsk_q && norm_req;

   // ---------------- pending next-state, one slice per source ----------------
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
      logic clr, set;
      assign clr = (push_ok && win_idx == SW'(g)) ||
                   (is_pclr && wdata_i[g]) ||
                   ((g == 0) && is_rd_fast && pend_q[0]);
      assign set = is_pset && wdata_i[g];
      assign pend_nxt[g] = mode_edge[g] ?
                           (irq_src_i[g] | set | (pend_q[g] & ~clr)) :
                           irq_src_i[g];
   end

   // ---------------- read mux ----------------
   always_comb begin
      rd_mux = '0;
      case (addr_i)
         RA_ACK_VEC:  rd_mux = win_valid ? DATA_W'(vec_q[win_idx]) : DATA_W'(spur_q);
         RA_FAST_VEC: rd_mux = (pend_q[0] || |(pend_q & ff_q)) ?
                               DATA_W'(vec_q[0]) : DATA_W'(spur_q);
         RA_TOP_SRC:  rd_mux = DATA_W'(st_top_src);
         RA_PEND:     rd_mux = DATA_W'(pend_q);
         RA_ENA:      rd_mux = DATA_W'(ena_q);
         RA_CORE:     rd_mux = DATA_W'({nirq_o, fiq_o});
         RA_SPUR:     rd_mux = DATA_W'(spur_q);
         RA_DBG:      rd_mux = DATA_W'({gmsk_q, prot_q});
         RA_FF_STAT:  rd_mux = DATA_W'(ff_q);
         default: begin
            if (sel_mode)
               rd_mux = DATA_W'({mode_edge[slot], 2'b00, mode_pri[slot]});
            else if (sel_vec)
               rd_mux = DATA_W'(vec_q[slot]);
         end
      endcase
   end

   assign rdata_o = rdata_q;

   // ---------------- registers ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_pri  <= '0;
         mode_edge <= '0;
         for (int i = 0; i < NUM_SRC; i++) vec_q[i] <= '0;
         spur_q    <= '0;
         prot_q    <= 1'b0;
         gmsk_q    <= 1'b0;
         pend_q    <= '0;
         ena_q     <= '0;
         ff_q      <= '0;
         rdata_q   <= '0;
      end else begin
         pend_q <= pend_nxt;
         if (rd_en_i) rdata_q <= rd_mux;
         if (wr_en_i) begin
            case (addr_i)
               RA_ENA_SET: ena_q  <= ena_q | wdata_i[NUM_SRC-1:0];
               RA_ENA_CLR: ena_q  <= ena_q & ~wdata_i[NUM_SRC-1:0];
               RA_FF_SET:  ff_q   <= ff_q | wdata_i[NUM_SRC-1:0];
               RA_FF_CLR:  ff_q   <= ff_q & ~wdata_i[NUM_SRC-1:0];
               RA_SPUR:    spur_q <= wdata_i[VEC_W-1:0];
               RA_DBG: begin
                  prot_q <= wdata_i[0];
                  gmsk_q <= wdata_i[1];
               end
               default: begin
                  if (sel_mode) begin
                     mode_pri[slot]  <= wdata_i[PRI_W-1:0];
                     mode_edge[slot] <= wdata_i[EDGE_POS];
                  end else if (sel_vec) begin
                     vec_q[slot] <= wdata_i[VEC_W-1:0];
                  end
               end
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   assert_nest_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      nirq_o |-> (st_empty || win_pri > st_top_pri));

   assert_winner_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_idx != '0) && pend_q[win_idx] && ena_q[win_idx] && !ff_q[win_idx]);

   assert_enable_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && addr_i == RA_ENA_SET |=>
         (ena_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0]));

   assert_gmask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      gmsk_q |-> !nirq_o && !fiq_o);

   assert_ack_pushes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> !st_empty);

endmodule

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb;
   localparam int NS    = 32;
   localparam int DEPTH = 4;
   localparam int VW    = 16;
   localparam logic [31:0] SPUR = 32'h0000BEEF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        nirq, fiq;

   always #2.5 clk = ~clk;

   nest_irq_ctrl #(.NUM_SRC(NS), .STACK_DEPTH(DEPTH), .VEC_W(VW)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_src_i(src), .rd_en_i(rd_en), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .nirq_o(nirq), .fiq_o(fiq)
   );

   int n_chk = 0, n_bad = 0;
   string cur_tag = "R11";

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_pend, m_ena, m_ff;
   int          m_pri [NS];
   bit          m_edge [NS];
   logic [31:0] m_vec [NS];
   logic [31:0] m_spu, m_rdata;
   bit          m_prot, m_gm, m_rdv;
   string       m_tag;
   int          stk_s [$];
   int          stk_p [$];

   function automatic void m_winner(output int w, output int p);
      w = 0; p = 0;
      for (int pr = 7; pr >= 0; pr--) begin
         for (int i = 1; i < NS; i++) begin
            if (w == 0 && m_pend[i] && m_ena[i] && !m_ff[i] && m_pri[i] == pr) begin
               w = i; p = pr;
            end
         end
      end
   endfunction

   function automatic bit m_nirq();
      int w, p;
      m_winner(w, p);
      if (m_gm || w == 0) return 1'b0;
      if (stk_s.size() == 0) return 1'b1;
      return p > stk_p[stk_p.size()-1];
   endfunction

   function automatic bit m_fiq();
      if (m_gm) return 1'b0;
      return ((m_pend & m_ena) & (m_ff | 32'h1)) != 0;
   endfunction

   always @(posedge clk) begin : model
      int w, p, idx;
      bit ack, fclr, pop, pushok;
      logic [31:0] setv, clrv, nxt;
      if (!rst_n) begin
         m_pend = 0; m_ena = 0; m_ff = 0; m_spu = 0; m_prot = 0; m_gm = 0;
         m_rdata = 0; m_rdv = 0;
         for (int i = 0; i < NS; i++) begin m_pri[i] = 0; m_edge[i] = 0; m_vec[i] = 0; end
         stk_s.delete(); stk_p.delete();
      end else begin
         m_winner(w, p);
         ack = 0; fclr = 0; pop = 0; setv = 0; clrv = 0; m_rdv = 0;
         if (rd_en) begin
            m_rdv = 1; m_tag = cur_tag; m_rdata = 0;
            case (addr)
               9'h100: begin
                  m_rdata = (w != 0) ? m_vec[w] : m_spu;
                  if (!m_prot && w != 0) ack = 1;
               end
               9'h104: begin
                  if (m_pend[0]) begin fclr = 1; m_rdata = m_vec[0]; end
                  else if ((m_pend & m_ff) != 0) m_rdata = m_vec[0];
                  else m_rdata = m_spu;
               end
               9'h108: m_rdata = (stk_s.size() == 0) ? 0 : stk_s[stk_s.size()-1];
               9'h10C: m_rdata = m_pend;
               9'h110: m_rdata = m_ena;
               9'h114: m_rdata = {30'd0, m_nirq(), m_fiq()};
               9'h134: m_rdata = m_spu;
               9'h138: m_rdata = {30'd0, m_gm, m_prot};
               9'h148: m_rdata = m_ff;
               default: if (addr < 9'h100 && addr[1:0] == 0) begin
                  idx = int'(addr[6:2]);
                  if (addr[7]) m_rdata = m_vec[idx];
                  else m_rdata = (32'(m_edge[idx]) << 5) | 32'(m_pri[idx]);
               end
            endcase
         end
         if (wr_en) begin
            if (addr == 9'h100 && m_prot && w != 0) ack = 1;
            if (addr == 9'h128) clrv = wdata;
            if (addr == 9'h12C) setv = wdata;
            if (addr == 9'h130) pop = 1;
         end
         pushok = ack && (stk_s.size() < DEPTH);
         for (int i = 0; i < NS; i++) begin
            if (m_edge[i])
               nxt[i] = src[i] | setv[i] |
                        (m_pend[i] & !((pushok && w == i) || clrv[i] || (i == 0 && fclr)));
            else
               nxt[i] = src[i];
         end
         if (pop && stk_s.size() > 0) begin void'(stk_s.pop_back()); void'(stk_p.pop_back()); end
         if (pushok) begin stk_s.push_back(w); stk_p.push_back(p); end
         m_pend = nxt;
         if (wr_en) begin
            case (addr)
               9'h120: m_ena = m_ena | wdata;
               9'h124: m_ena = m_ena & ~wdata;
               9'h140: m_ff = m_ff | wdata;
               9'h144: m_ff = m_ff & ~wdata;
               9'h134: m_spu = {16'd0, wdata[15:0]};
               9'h138: begin m_prot = wdata[0]; m_gm = wdata[1]; end
               default: if (addr < 9'h100 && addr[1:0] == 0) begin
                  idx = int'(addr[6:2]);
                  if (addr[7]) m_vec[idx] = {16'd0, wdata[15:0]};
                  else begin m_pri[idx] = int'(wdata[2:0]); m_edge[idx] = wdata[5]; end
               end
            endcase
         end
      end
   end

   // per-clock comparison, away from the active edge
   bit run_cmp = 0;
   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         check(nirq === m_nirq(), "R5 normal request vs model", 32'(nirq), 32'(m_nirq()));
         check(fiq === m_fiq(), "R8 fast request vs model", 32'(fiq), 32'(m_fiq()));
         if (m_rdv) check(rdata === m_rdata, m_tag, rdata, m_rdata);
      end
   end

   // ---------------- tasks (all start and end at a falling edge) ----------------
   task automatic step();
      @(posedge clk); #1; @(negedge clk);
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      wr_en = 1; addr = a; wdata = d;
      @(posedge clk); #1 wr_en = 0;
      @(negedge clk);
   endtask

   task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp, input string tag);
      cur_tag = tag; rd_en = 1; addr = a;
      @(posedge clk); #1 rd_en = 0;
      @(negedge clk);
      check(rdata === exp, tag, rdata, exp);
   endtask

   task automatic pin_chk(input logic act, input logic exp, input string tag);
      check(act === exp, tag, 32'(act), 32'(exp));
   endtask

   task automatic pulse(input int k);
      src[k] = 1'b1;
      @(posedge clk); #1 src[k] = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      pin_chk(nirq, 1'b0, "R1 normal request in reset");
      pin_chk(fiq,  1'b0, "R1 fast request in reset");
      rst_n = 1;
      run_cmp = 1;
      step();
      // R1 reset state
      rd_chk(9'h10C, 0, "R1 pending after reset");
      rd_chk(9'h110, 0, "R1 enabled after reset");
      rd_chk(9'h108, 0, "R1 stack top after reset");
      rd_chk(9'h114, 0, "R1 core status after reset");
      rd_chk(9'h138, 0, "R1 debug control after reset");
      rd_chk(9'h148, 0, "R1 fast set after reset");
      rd_chk(9'h134, 0, "R1 spurious vector after reset");

      // configuration
      for (int i = 0; i < NS; i++) wr(9'(9'h080 + 4*i), 32'h100 + i);
      wr(9'h134, SPUR);
      wr(9'h00C, 32'h22);   // src3 edge pri2
      wr(9'h014, 32'h05);   // src5 level pri5
      wr(9'h01C, 32'h25);   // src7 edge pri5
      wr(9'h024, 32'h21);   // src9 edge pri1
      wr(9'h030, 32'h00);   // src12 level pri0
      wr(9'h120, 32'hFFFF_FFFF);
      rd_chk(9'h01C, 32'h25, "R2 mode word layout readback");
      rd_chk(9'h08C, 32'h103, "R11 vector slot address");
      rd_chk(9'h110, 32'hFFFF_FFFF, "R9 enable set");

      // R4 spurious
      rd_chk(9'h100, SPUR, "R4 spurious vector with nothing pending");
      rd_chk(9'h108, 0, "R4 no push on spurious");

      // R2 edge holds, level follows
      pulse(3);
      pulse(5);
      step();
      rd_chk(9'h10C, 32'h08, "R2 edge held and level dropped");

      // R3 tie at equal priority, R5 strictly greater
      src[5] = 1'b1;
      pulse(7);
      rd_chk(9'h100, 32'h105, "R3 tie goes to lowest source");
      rd_chk(9'h108, 32'd5, "R7 stack top after acknowledge");
      pin_chk(nirq, 1'b0, "R5 equal priority does not preempt");

      wr(9'h02C, 32'h27);   // src11 edge pri7
      wr(9'h12C, 32'h800);
      pin_chk(nirq, 1'b1, "R5 higher priority preempts");
      rd_chk(9'h100, 32'h10B, "R3 highest priority wins");
      rd_chk(9'h10C, 32'hA8, "R4 edge pending cleared by acknowledge");
      rd_chk(9'h108, 32'd11, "R7 nested top");
      pin_chk(nirq, 1'b0, "R5 nothing above priority 7");

      // R9 commands act on edge sources only
      wr(9'h128, 32'h80);
      wr(9'h12C, 32'h1000);
      wr(9'h128, 32'h20);
      rd_chk(9'h10C, 32'h28, "R9 clear edge, level set and clear ignored");

      // R7 end of service
      wr(9'h130, 0);
      rd_chk(9'h108, 32'd5, "R7 pop reveals older entry");
      wr(9'h130, 0);
      rd_chk(9'h108, 0, "R7 empty stack reads zero");
      wr(9'h130, 0);
      rd_chk(9'h108, 0, "R7 pop on empty stack");
      pin_chk(nirq, 1'b1, "R5 request with empty stack");

      // R4 full stack refuses push
      for (int k = 0; k < DEPTH + 1; k++) rd_chk(9'h100, 32'h105, "R4 repeated acknowledge");
      for (int k = 0; k < DEPTH - 1; k++) wr(9'h130, 0);
      rd_chk(9'h108, 32'd5, "R4 one entry left after overflow attempt");
      wr(9'h130, 0);
      rd_chk(9'h108, 0, "R4 stack held exactly depth entries");
      src[5] = 1'b0;
      step();
      wr(9'h128, 32'h08);
      rd_chk(9'h10C, 0, "R9 pending cleared");

      // R6 protect mode
      wr(9'h138, 32'h1);
      wr(9'h12C, 32'h08);
      pin_chk(nirq, 1'b1, "R6 request raised");
      rd_chk(9'h100, 32'h103, "R6 protected read returns vector");
      rd_chk(9'h10C, 32'h08, "R6 protected read leaves pending");
      rd_chk(9'h108, 0, "R6 protected read does not push");
      wr(9'h100, 0);
      rd_chk(9'h108, 32'd3, "R6 write acknowledges");
      rd_chk(9'h10C, 0, "R6 write clears edge pending");
      wr(9'h138, 32'h0);
      wr(9'h130, 0);
      wr(9'h12C, 32'h08);
      wr(9'h100, 0);
      rd_chk(9'h108, 0, "R6 write ignored outside protect");
      wr(9'h128, 32'h08);

      // R8 fast path
      wr(9'h000, 32'h20);
      pulse(0);
      pin_chk(fiq, 1'b1, "R8 source 0 raises fast request");
      rd_chk(9'h104, 32'h100, "R8 fast vector for source 0");
      rd_chk(9'h10C, 0, "R8 fast read clears source 0");
      pin_chk(fiq, 1'b0, "R8 fast request dropped");
      rd_chk(9'h104, SPUR, "R8 fast spurious");
      wr(9'h140, 32'h200);
      wr(9'h12C, 32'h200);
      pin_chk(fiq, 1'b1, "R8 forced source raises fast request");
      pin_chk(nirq, 1'b0, "R3 forced source leaves normal path");
      rd_chk(9'h104, 32'h100, "R8 forced source gives vector 0");
      rd_chk(9'h10C, 32'h200, "R8 forced pending kept");
      rd_chk(9'h100, SPUR, "R3 forced source never wins");
      rd_chk(9'h108, 0, "R4 no push when spurious");
      wr(9'h144, 32'h200);
      pin_chk(nirq, 1'b1, "R9 fast force cleared");
      pin_chk(fiq, 1'b0, "R8 fast request gone");
      rd_chk(9'h148, 0, "R11 fast set readback");

      // R10 global mask
      wr(9'h138, 32'h2);
      pin_chk(nirq, 1'b0, "R10 mask silences normal request");
      rd_chk(9'h114, 0, "R10 core status masked");
      wr(9'h138, 32'h0);
      rd_chk(9'h114, 32'h2, "R10 core status normal bit");
      wr(9'h124, 32'h200);
      pin_chk(nirq, 1'b0, "R9 disable drops request");
      rd_chk(9'h110, 32'hFFFF_FDFF, "R9 disable clears bit");

      // random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         int sel;
         logic [8:0] a;
         src = $urandom & $urandom & $urandom & $urandom;
         sel = $urandom_range(0, 15);
         case (sel)
            0: a = 9'h100;  1: a = 9'h104;  2: a = 9'h108;  3: a = 9'h10C;
            4: a = 9'h114;  5: a = 9'h130;  6: a = 9'h12C;  7: a = 9'h128;
            8: a = 9'h120;  9: a = 9'h124; 10: a = 9'h140; 11: a = 9'h144;
            12: a = 9'h138; 13: a = 9'(4 * $urandom_range(0, 31));
            14: a = 9'(9'h080 + 4 * $urandom_range(0, 31));
            default: a = 9'h100;
         endcase
         if ($urandom_range(0, 1) == 0) begin
            cur_tag = "R4 random read vs model";
            rd_en = 1; addr = a;
         end else begin
            wr_en = 1; addr = a;
            wdata = (a == 9'h138) ? 32'($urandom_range(0, 3)) :
                    (a == 9'h124 || a == 9'h140) ? ($urandom & $urandom) : $urandom;
         end
         @(posedge clk); #1 rd_en = 0; wr_en = 0;
         @(negedge clk);
      end
      src = '0;
      step();
      finish_run();
   end
endmodule